// File: doc/BRIEF.md
# ASID-Tagged Address Translation Cache with Page-Table Refill

This block turns virtual addresses into physical addresses for a single-level paging unit. Each request carries a virtual address and the identifier of the address space that issued it. The upper address bits form the virtual page number and the low bits form the in-page offset. A small fully associative cache holds recent page-to-frame mappings. Every mapping is tagged with the identifier of its owning address space, so mappings from several processes can sit side by side.

On a hit, the cached frame number replaces the page number and the offset passes through unchanged. On a miss, an internal walker issues one word read to a memory port. The read address is the page-table base plus the page number scaled by the entry size. If the returned entry is marked valid, the walker installs the mapping and completes the translation. If the entry is not valid, it reports a fault and installs nothing.

A context switch needs only two things: reload the table base through a load strobe, and present a different identifier with later requests. A flush strobe empties the whole cache.

Top module: `asid_tlb`

## Requirements
- R1: After reset, `req_ready` is 1, `resp_valid` is 0 and `mem_req_valid` is 0, and the cache is empty, so the first request of any page starts a walk.
- R2: A request whose page number and identifier both match a cached mapping produces `resp_valid`=1 and `resp_hit`=1 in the cycle after acceptance, with no memory read. `resp_paddr` is the frame number in bits [31:12] and the request offset (bits [11:0]) in the low bits.
- R3: A request whose page number matches a cached mapping but whose identifier differs is treated as a miss and starts a walk.
- R4: On a miss, the walker raises `mem_req_valid` in the cycle after acceptance, with `mem_req_addr` = table base + page number × 4. It holds the request and its address stable until `mem_req_ready`, and never has more than one read outstanding.
- R5: A walk response produces `resp_valid`=1 with `resp_hit`=0 in the cycle after `mem_rsp_valid`. When the entry is valid, `resp_paddr` is the entry's bits [19:0] followed by the request offset.
- R6: After a walk that returns a valid entry, a later request for the same page and identifier hits, and at most one cached mapping ever matches a given lookup.
- R7: A page-table entry with bit 31 clear produces `resp_fault`=1, `resp_hit`=0 and `resp_paddr`=0, and is not installed, so a repeat request walks again.
- R8: A walk installs into the lowest-numbered empty slot if one exists. Otherwise it installs into the slot named by a rotating pointer. The pointer starts at 0 after reset and advances by one, wrapping after the last slot, on each such eviction. With 8 slots, filling 8 pages and then a ninth evicts the first page filled.
- R9: A `flush` pulse empties every slot. When a flush falls in the same cycle as a walk's install, the flush wins and the walked mapping is not kept.
- R10: A `ptbr_load` pulse sets the table base used by walks of requests accepted in later cycles. Cached mappings of every identifier survive the change and still hit when their identifier is presented again.
- R11: `req_ready` is 0 from acceptance until the response cycle has passed. No request is taken while a translation is in progress, and each response lasts exactly one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Translation request present |
| req_ready | output | 1 | Block can accept a request |
| req_vaddr | input | 32 | Virtual address |
| req_asid | input | 8 | Address-space identifier of the requester |
| resp_valid | output | 1 | Translation result valid (one cycle) |
| resp_paddr | output | 32 | Physical address (0 on fault) |
| resp_hit | output | 1 | Result came from the cache |
| resp_fault | output | 1 | Page-table entry was not valid |
| ptbr_load | input | 1 | Load a new page-table base |
| ptbr_value | input | 32 | New page-table base address |
| flush | input | 1 | Empty every cached mapping |
| mem_req_valid | output | 1 | Page-table read request |
| mem_req_ready | input | 1 | Memory accepts the read |
| mem_req_addr | output | 32 | Byte address of the page-table entry |
| mem_rsp_valid | input | 1 | Read data present |
| mem_rsp_data | input | 32 | Page-table entry (bit 31 valid, bits [19:0] frame) |

## Verification
The two functions that can land on the same clock edge are a walk installing its mapping and a flush emptying the cache. The bench provokes this by raising `flush` in exactly the cycle it presents `mem_rsp_valid`, both in a directed case and at random. It judges the outcome by the next request to that page, which must start a new page-table read instead of hitting. A table-base reload between walks is mixed in the same way, and is judged by the address of the following read and by the hits of the earlier identifier.

// File: rtl/tlb_pkg.sv
// Shared types for the translation cache.
// Assumes: nothing beyond IEEE 1800-2017 packages.
package tlb_pkg;

    // Walker sequencing states.
    typedef enum logic [1:0] {
        W_IDLE  = 2'd0,
        W_ISSUE = 2'd1,
        W_WAIT  = 2'd2,
        W_RESP  = 2'd3
    } walk_state_t;

endpackage

// File: rtl/tlb_cam.sv
// Fully associative mapping store: compares a page number and identifier
// against every slot in parallel, and writes one slot per cycle.
// Assumes: the caller never installs a mapping that already matches, so at
// most one slot hits. A flush has priority over a write in the same cycle.
module tlb_cam #(
    parameter int ENTRIES = 8,
    parameter int VPN_W   = 20,
    parameter int PFN_W   = 20,
    parameter int ASID_W  = 8,
    localparam int IDX_W  = $clog2(ENTRIES)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [VPN_W-1:0]   lk_vpn,
    input  logic [ASID_W-1:0]  lk_asid,
    output logic               lk_hit,
    output logic [PFN_W-1:0]   lk_pfn,
    output logic [ENTRIES-1:0] hit_vec,
    output logic [ENTRIES-1:0] valid_vec,
    input  logic               flush,
    input  logic               wr_en,
    input  logic [IDX_W-1:0]   wr_idx,
    input  logic [VPN_W-1:0]   wr_vpn,
    input  logic [ASID_W-1:0]  wr_asid,
    input  logic [PFN_W-1:0]   wr_pfn
);

    logic [VPN_W-1:0]  ent_vpn  [ENTRIES];
    logic [ASID_W-1:0] ent_asid [ENTRIES];
    logic [PFN_W-1:0]  ent_pfn  [ENTRIES];
    logic [ENTRIES-1:0] ent_valid;

    // Slot storage: flush clears valid bits, otherwise one slot is written.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ent_valid <= '0;
            for (int i = 0; i < ENTRIES; i++) begin
                ent_vpn[i]  <= '0;
                ent_asid[i] <= '0;
                ent_pfn[i]  <= '0;
            end
        end else if (flush) begin
            ent_valid <= '0;
        end else if (wr_en) begin
            for (int i = 0; i < ENTRIES; i++) begin
                if (wr_idx == IDX_W'(i)) begin
                    ent_valid[i] <= 1'b1;
                    ent_vpn[i]   <= wr_vpn;
                    ent_asid[i]  <= wr_asid;
                    ent_pfn[i]   <= wr_pfn;
                end
            end
        end
    end

    // Per-slot compare of page number and identifier.
    for (genvar g = 0; g < ENTRIES; g++) begin : g_match
        assign hit_vec[g] = ent_valid[g] && (ent_vpn[g] == lk_vpn)
                            && (ent_asid[g] == lk_asid);
    end

    // Merge the single matching frame number onto one bus.
    always_comb begin
        lk_pfn = '0;
        for (int i = 0; i < ENTRIES; i++) begin
            if (hit_vec[i]) lk_pfn = lk_pfn | ent_pfn[i];
        end
    end

    assign lk_hit    = |hit_vec;
    assign valid_vec = ent_valid;

endmodule

// File: rtl/tlb_victim.sv
// Picks the slot a walk installs into: the lowest empty slot, or else the
// slot named by a rotating pointer that advances on each eviction.
// Assumes: `install` pulses once per accepted walk result; valid_vec is the
// state before that install.
module tlb_victim #(
    parameter int ENTRIES = 8,
    localparam int IDX_W  = $clog2(ENTRIES)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [ENTRIES-1:0] valid_vec,
    input  logic               install,
    output logic [IDX_W-1:0]   victim_idx
);

    logic [IDX_W-1:0] rr_ptr;
    logic [IDX_W-1:0] free_idx;
    logic             free_found;

    // Search for the lowest-numbered empty slot.
    always_comb begin
        free_found = 1'b0;
        free_idx   = '0;
        for (int i = ENTRIES - 1; i >= 0; i--) begin
            if (!valid_vec[i]) begin
                free_found = 1'b1;
                free_idx   = IDX_W'(i);
            end
        end
    end

    assign victim_idx = free_found ? free_idx : rr_ptr;

    // Rotating pointer: steps only when an occupied slot is overwritten.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rr_ptr <= '0;
        end else if (install && !free_found) begin
            if (rr_ptr == IDX_W'(ENTRIES - 1)) rr_ptr <= '0;
            else                               rr_ptr <= rr_ptr + 1'b1;
        end
    end

endmodule

// File: rtl/tlb_walker.sv
// Request sequencer: accepts one translation, answers a hit directly or runs
// a single page-table read, then presents a one-cycle result.
// Assumes: the lookup result is combinational on the request inputs; the
// memory returns exactly one response per accepted read.
module tlb_walker
    import tlb_pkg::*;
#(
    parameter int VA_W      = 32,
    parameter int PAGE_BITS = 12,
    parameter int ASID_W    = 8,
    parameter int PFN_W     = 20,
    parameter int PTE_W     = 32,
    parameter int ADDR_W    = 32,
    localparam int VPN_W    = VA_W - PAGE_BITS,
    localparam int PA_W     = PFN_W + PAGE_BITS,
    localparam int PTE_SH   = $clog2(PTE_W / 8),
    localparam int PAD_W    = ADDR_W - VPN_W - PTE_SH
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [VA_W-1:0]   req_vaddr,
    input  logic [ASID_W-1:0] req_asid,
    input  logic [ADDR_W-1:0] ptbr,
    input  logic              lookup_hit,
    input  logic [PFN_W-1:0]  lookup_pfn,
    output logic              mem_req_valid,
    input  logic              mem_req_ready,
    output logic [ADDR_W-1:0] mem_req_addr,
    input  logic              mem_rsp_valid,
    input  logic [PTE_W-1:0]  mem_rsp_data,
    output logic              resp_valid,
    output logic [PA_W-1:0]   resp_paddr,
    output logic              resp_hit,
    output logic              resp_fault,
    output logic              install,
    output logic [VPN_W-1:0]  install_vpn,
    output logic [ASID_W-1:0] install_asid,
    output logic [PFN_W-1:0]  install_pfn,
    output logic              walk_wait
);

    walk_state_t           st;
    logic [VPN_W-1:0]      cur_vpn;
    logic [ASID_W-1:0]     cur_asid;
    logic [PAGE_BITS-1:0]  cur_off;
    logic [ADDR_W-1:0]     wk_addr;
    logic                  pte_ok;
    logic [VPN_W-1:0]      in_vpn;

    assign in_vpn = req_vaddr[VA_W-1:PAGE_BITS];
    assign pte_ok = mem_rsp_data[PTE_W-1];

    // Main sequencer and result registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st         <= W_IDLE;
            cur_vpn    <= '0;
            cur_asid   <= '0;
            cur_off    <= '0;
            wk_addr    <= '0;
            resp_paddr <= '0;
            resp_hit   <= 1'b0;
            resp_fault <= 1'b0;
        end else begin
            case (st)
                W_IDLE: begin
                    if (req_valid) begin
                        cur_vpn  <= in_vpn;
                        cur_asid <= req_asid;
                        cur_off  <= req_vaddr[PAGE_BITS-1:0];
                        wk_addr  <= ptbr + {{PAD_W{1'b0}}, in_vpn, {PTE_SH{1'b0}}};
                        if (lookup_hit) begin
                            resp_paddr <= {lookup_pfn, req_vaddr[PAGE_BITS-1:0]};
                            resp_hit   <= 1'b1;
                            resp_fault <= 1'b0;
                            st         <= W_RESP;
                        end else begin
                            st <= W_ISSUE;
                        end
                    end
                end
                W_ISSUE: begin
                    if (mem_req_ready) st <= W_WAIT;
                end
                W_WAIT: begin
                    if (mem_rsp_valid) begin
                        resp_hit <= 1'b0;
                        if (pte_ok) begin
                            resp_paddr <= {mem_rsp_data[PFN_W-1:0], cur_off};
                            resp_fault <= 1'b0;
                        end else begin
                            resp_paddr <= '0;
                            resp_fault <= 1'b1;
                        end
                        st <= W_RESP;
                    end
                end
                default: st <= W_IDLE;
            endcase
        end
    end

    assign req_ready     = (st == W_IDLE);
    assign mem_req_valid = (st == W_ISSUE);
    assign mem_req_addr  = wk_addr;
    assign resp_valid    = (st == W_RESP);
    assign walk_wait     = (st == W_WAIT);

    assign install      = walk_wait && mem_rsp_valid && pte_ok;
    assign install_vpn  = cur_vpn;
    assign install_asid = cur_asid;
    assign install_pfn  = mem_rsp_data[PFN_W-1:0];

    logic unused_pte_bits;
    assign unused_pte_bits = ^mem_rsp_data[PTE_W-2:PFN_W];

endmodule

// File: rtl/asid_tlb.sv
// Top of the translation cache: holds the page-table base and ties the
// mapping store, the victim chooser and the walk sequencer together.
// Assumes: one request in flight; page-table entries are PTE_W bits with the
// valid flag in the top bit and the frame number in the low PFN_W bits.
module asid_tlb #(
    parameter int VA_W      = 32,
    parameter int PAGE_BITS = 12,
    parameter int ASID_W    = 8,
    parameter int PFN_W     = 20,
    parameter int PTE_W     = 32,
    parameter int ADDR_W    = 32,
    parameter int ENTRIES   = 8,
    localparam int VPN_W    = VA_W - PAGE_BITS,
    localparam int PA_W     = PFN_W + PAGE_BITS,
    localparam int IDX_W    = $clog2(ENTRIES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [VA_W-1:0]   req_vaddr,
    input  logic [ASID_W-1:0] req_asid,
    output logic              resp_valid,
    output logic [PA_W-1:0]   resp_paddr,
    output logic              resp_hit,
    output logic              resp_fault,
    input  logic              ptbr_load,
    input  logic [ADDR_W-1:0] ptbr_value,
    input  logic              flush,
    output logic              mem_req_valid,
    input  logic              mem_req_ready,
    output logic [ADDR_W-1:0] mem_req_addr,
    input  logic              mem_rsp_valid,
    input  logic [PTE_W-1:0]  mem_rsp_data
);

    logic [ADDR_W-1:0]  ptbr_q;
    logic               lk_hit;
    logic [PFN_W-1:0]   lk_pfn;
    logic [ENTRIES-1:0] cam_hit_vec;
    logic [ENTRIES-1:0] cam_valid_vec;
    logic               install;
    logic [VPN_W-1:0]   install_vpn;
    logic [ASID_W-1:0]  install_asid;
    logic [PFN_W-1:0]   install_pfn;
    logic [IDX_W-1:0]   victim_idx;
    logic               walk_wait;

    // Page-table base register, reloaded on a context switch.
    always_ff @(posedge clk) begin
        if (!rst_n)         ptbr_q <= '0;
        else if (ptbr_load) ptbr_q <= ptbr_value;
    end

    tlb_cam #(
        .ENTRIES (ENTRIES),
        .VPN_W   (VPN_W),
        .PFN_W   (PFN_W),
        .ASID_W  (ASID_W)
    ) u_cam (
        .clk       (clk),
        .rst_n     (rst_n),
        .lk_vpn    (req_vaddr[VA_W-1:PAGE_BITS]),
        .lk_asid   (req_asid),
        .lk_hit    (lk_hit),
        .lk_pfn    (lk_pfn),
        .hit_vec   (cam_hit_vec),
        .valid_vec (cam_valid_vec),
        .flush     (flush),
        .wr_en     (install),
        .wr_idx    (victim_idx),
        .wr_vpn    (install_vpn),
        .wr_asid   (install_asid),
        .wr_pfn    (install_pfn)
    );

    tlb_victim #(
        .ENTRIES (ENTRIES)
    ) u_victim (
        .clk        (clk),
        .rst_n      (rst_n),
        .valid_vec  (cam_valid_vec),
        .install    (install && !flush),
        .victim_idx (victim_idx)
    );

    tlb_walker #(
        .VA_W      (VA_W),
        .PAGE_BITS (PAGE_BITS),
        .ASID_W    (ASID_W),
        .PFN_W     (PFN_W),
        .PTE_W     (PTE_W),
        .ADDR_W    (ADDR_W)
    ) u_walker (
        .clk           (clk),
        .rst_n         (rst_n),
        .req_valid     (req_valid),
        .req_ready     (req_ready),
        .req_vaddr     (req_vaddr),
        .req_asid      (req_asid),
        .ptbr          (ptbr_q),
        .lookup_hit    (lk_hit),
        .lookup_pfn    (lk_pfn),
        .mem_req_valid (mem_req_valid),
        .mem_req_ready (mem_req_ready),
        .mem_req_addr  (mem_req_addr),
        .mem_rsp_valid (mem_rsp_valid),
        .mem_rsp_data  (mem_rsp_data),
        .resp_valid    (resp_valid),
        .resp_paddr    (resp_paddr),
        .resp_hit      (resp_hit),
        .resp_fault    (resp_fault),
        .install       (install),
        .install_vpn   (install_vpn),
        .install_asid  (install_asid),
        .install_pfn   (install_pfn),
        .walk_wait     (walk_wait)
    );

    logic unused_obs;
    assign unused_obs = walk_wait ^ (^cam_hit_vec);

endmodule

// File: rtl/asid_tlb_checker.sv
// Protocol and timing properties of the translation cache, bound to the top.
// Assumes: synchronous active-low reset; observes ports and a few internal
// nets of the top.
module asid_tlb_checker #(
    parameter int ENTRIES = 8,
    parameter int ADDR_W  = 32
) (
    input logic               clk,
    input logic               rst_n,
    input logic               req_valid,
    input logic               req_ready,
    input logic               resp_valid,
    input logic               resp_hit,
    input logic               resp_fault,
    input logic               mem_req_valid,
    input logic               mem_req_ready,
    input logic [ADDR_W-1:0]  mem_req_addr,
    input logic               mem_rsp_valid,
    input logic               walk_wait,
    input logic [ENTRIES-1:0] hit_vec
);

    // R11: no acceptance while a read is being issued.
    a_r11_busy_not_ready: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid |-> !req_ready);

    // R11: each response lasts one cycle.
    a_r11_single_resp: assert property (@(posedge clk) disable iff (!rst_n)
        resp_valid |=> !resp_valid);

    // R4: the read request and its address hold until taken.
    a_r4_hold_read: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_addr));

    // R5: the walk result follows the memory data by one cycle.
    a_r5_walk_resp: assert property (@(posedge clk) disable iff (!rst_n)
        walk_wait && mem_rsp_valid |=> resp_valid && !resp_hit);

    // R2: a hit result follows an acceptance by one cycle.
    a_r2_hit_timing: assert property (@(posedge clk) disable iff (!rst_n)
        resp_valid && resp_hit |-> $past(req_valid && req_ready));

    // R7: a fault is never reported as a hit.
    a_r7_fault_no_hit: assert property (@(posedge clk) disable iff (!rst_n)
        resp_valid && resp_fault |-> !resp_hit);

    // R6: no two slots hold the same page and identifier.
    a_r6_unique_match: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(hit_vec));

endmodule

bind asid_tlb asid_tlb_checker #(
    .ENTRIES (ENTRIES),
    .ADDR_W  (ADDR_W)
) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .req_valid     (req_valid),
    .req_ready     (req_ready),
    .resp_valid    (resp_valid),
    .resp_hit      (resp_hit),
    .resp_fault    (resp_fault),
    .mem_req_valid (mem_req_valid),
    .mem_req_ready (mem_req_ready),
    .mem_req_addr  (mem_req_addr),
    .mem_rsp_valid (mem_rsp_valid),
    .walk_wait     (walk_wait),
    .hit_vec       (cam_hit_vec)
);

// File: tb/asid_tlb_bench.sv
// Self-checking bench: directed corner cases plus seeded random traffic,
// compared against a requirement-level model of the mapping cache.
module asid_tlb_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [31:0] req_vaddr = '0;
    logic [7:0]  req_asid = '0;
    logic        resp_valid;
    logic [31:0] resp_paddr;
    logic        resp_hit;
    logic        resp_fault;
    logic        ptbr_load = 1'b0;
    logic [31:0] ptbr_value = '0;
    logic        flush = 1'b0;
    logic        mem_req_valid;
    logic        mem_req_ready = 1'b0;
    logic [31:0] mem_req_addr;
    logic        mem_rsp_valid = 1'b0;
    logic [31:0] mem_rsp_data = '0;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    // Model state
    bit          m_valid [8];
    logic [19:0] m_vpn   [8];
    logic [7:0]  m_asid  [8];
    logic [19:0] m_pfn   [8];
    int          m_rr = 0;
    logic [31:0] m_ptbr = '0;

    always #2 clk = ~clk;

    asid_tlb u_asid_tlb (
        .clk           (clk),
        .rst_n         (rst_n),
        .req_valid     (req_valid),
        .req_ready     (req_ready),
        .req_vaddr     (req_vaddr),
        .req_asid      (req_asid),
        .resp_valid    (resp_valid),
        .resp_paddr    (resp_paddr),
        .resp_hit      (resp_hit),
        .resp_fault    (resp_fault),
        .ptbr_load     (ptbr_load),
        .ptbr_value    (ptbr_value),
        .flush         (flush),
        .mem_req_valid (mem_req_valid),
        .mem_req_ready (mem_req_ready),
        .mem_req_addr  (mem_req_addr),
        .mem_rsp_valid (mem_rsp_valid),
        .mem_rsp_data  (mem_rsp_data)
    );

    function automatic logic [19:0] pfn_of(input logic [31:0] addr);
        logic [31:0] h;
        h = addr * 32'h9E37_79B1;
        return h[31:12];
    endfunction

    function automatic int model_find(input logic [19:0] vpn, input logic [7:0] asid);
        for (int i = 0; i < 8; i++)
            if (m_valid[i] && m_vpn[i] == vpn && m_asid[i] == asid) return i;
        return -1;
    endfunction

    function automatic void model_install(input logic [19:0] vpn, input logic [7:0] asid,
                                          input logic [19:0] pfn);
        int slot;
        slot = -1;
        for (int i = 7; i >= 0; i--) if (!m_valid[i]) slot = i;
        if (slot < 0) begin
            slot = m_rr;
            m_rr = (m_rr + 1) % 8;
        end
        m_valid[slot] = 1'b1;
        m_vpn[slot]   = vpn;
        m_asid[slot]  = asid;
        m_pfn[slot]   = pfn;
    endfunction

    function automatic void model_flush();
        for (int i = 0; i < 8; i++) m_valid[i] = 1'b0;
    endfunction

    task automatic chk(input bit ok, input string tag, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    // One translation; bad forces an invalid entry, fl raises flush with the data.
    task automatic translate(input logic [31:0] va, input logic [7:0] asid,
                             input bit bad, input bit fl, input int lat, input string tag);
        logic [19:0] vpn;
        logic [31:0] waddr;
        logic [19:0] pfn;
        int          slot;
        vpn  = va[31:12];
        slot = model_find(vpn, asid);
        @(negedge clk);
        chk(req_ready == 1'b1, "R11", "ready before request", 64'(req_ready), 64'd1);
        req_valid = 1'b1;
        req_vaddr = va;
        req_asid  = asid;
        @(negedge clk);
        if (slot >= 0) begin
            req_valid = 1'b0;
            chk(resp_valid && resp_hit, tag, "hit response", {resp_valid, resp_hit}, 2'b11);
            chk(resp_paddr == {m_pfn[slot], va[11:0]}, tag, "hit paddr",
                64'(resp_paddr), 64'({m_pfn[slot], va[11:0]}));
            chk(!mem_req_valid, "R2", "no read on hit", 64'(mem_req_valid), 64'd0);
        end else begin
            waddr = m_ptbr + {10'b0, vpn, 2'b00};
            pfn   = pfn_of(waddr);
            // keep offering another request while busy: it must be ignored
            req_vaddr = ~va;
            chk(!resp_valid, tag, "no early response", 64'(resp_valid), 64'd0);
            chk(mem_req_valid, tag, "walk started", 64'(mem_req_valid), 64'd1);
            chk(mem_req_addr == waddr, "R4", "walk address", 64'(mem_req_addr), 64'(waddr));
            chk(!req_ready, "R11", "busy during walk", 64'(req_ready), 64'd0);
            for (int k = 0; k < lat; k++) begin
                @(negedge clk);
                chk(mem_req_valid && mem_req_addr == waddr, "R4", "read held",
                    64'(mem_req_addr), 64'(waddr));
            end
            mem_req_ready = 1'b1;
            @(negedge clk);
            mem_req_ready = 1'b0;
            chk(!mem_req_valid, "R4", "single read", 64'(mem_req_valid), 64'd0);
            for (int k = 0; k < lat; k++) begin
                @(negedge clk);
                chk(!resp_valid && !mem_req_valid, "R5", "quiet while waiting",
                    {resp_valid, mem_req_valid}, 2'b00);
            end
            mem_rsp_valid = 1'b1;
            mem_rsp_data  = {~bad, 11'h0, pfn};
            flush         = fl;
            @(negedge clk);
            mem_rsp_valid = 1'b0;
            flush         = 1'b0;
            req_valid     = 1'b0;
            chk(resp_valid && !resp_hit, "R5", "walk response", {resp_valid, resp_hit}, 2'b10);
            if (bad) begin
                chk(resp_fault && resp_paddr == 32'h0, "R7", "fault result",
                    {resp_fault, resp_paddr}, {1'b1, 32'h0});
            end else begin
                chk(!resp_fault && resp_paddr == {pfn, va[11:0]}, tag, "walk paddr",
                    {resp_fault, resp_paddr}, {1'b0, pfn, va[11:0]});
            end
            if (fl) model_flush();
            else if (!bad) model_install(vpn, asid, pfn);
        end
        @(negedge clk);
        chk(!resp_valid && req_ready, "R11", "one-cycle response",
            {resp_valid, req_ready}, 2'b01);
    endtask

    task automatic do_flush();
        @(negedge clk);
        flush = 1'b1;
        @(negedge clk);
        flush = 1'b0;
        model_flush();
    endtask

    task automatic load_base(input logic [31:0] b);
        @(negedge clk);
        ptbr_load  = 1'b1;
        ptbr_value = b;
        @(negedge clk);
        ptbr_load = 1'b0;
        m_ptbr    = b;
    endtask

    // Watchdog
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL R11 watchdog expired: actual hung expected finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1234));
        for (int i = 0; i < 8; i++) m_valid[i] = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(req_ready && !resp_valid && !mem_req_valid, "R1", "reset outputs",
            {req_ready, resp_valid, mem_req_valid}, 3'b100);

        load_base(32'h0010_0000);
        translate(32'h0001_2345, 8'd1, 1'b0, 1'b0, 1, "R1");
        translate(32'h0001_2345, 8'd1, 1'b0, 1'b0, 0, "R2");
        translate(32'h0001_2ABC, 8'd1, 1'b0, 1'b0, 0, "R6");
        // R3 same page other identifier
        translate(32'h0001_2777, 8'd2, 1'b0, 1'b0, 2, "R3");
        translate(32'h0001_2001, 8'd2, 1'b0, 1'b0, 0, "R3");
        translate(32'h0001_2002, 8'd1, 1'b0, 1'b0, 0, "R3");
        // R7 invalid entry then retry must walk again
        translate(32'h0004_0010, 8'd1, 1'b1, 1'b0, 1, "R7");
        translate(32'h0004_0020, 8'd1, 1'b0, 1'b0, 0, "R7");
        // R9 flush empties everything
        do_flush();
        translate(32'h0001_2345, 8'd1, 1'b0, 1'b0, 0, "R9");
        // R8 fill 8 pages then a ninth
        do_flush();
        for (int p = 0; p < 9; p++)
            translate({20'h00100 + 20'(p), 12'h010}, 8'd5, 1'b0, 1'b0, 0, "R8");
        for (int p = 1; p < 8; p++)
            translate({20'h00100 + 20'(p), 12'h020}, 8'd5, 1'b0, 1'b0, 0, "R8");
        translate(32'h0010_0030, 8'd5, 1'b0, 1'b0, 0, "R8");
        // R9 flush in the install cycle wins
        translate(32'h0077_7000, 8'd6, 1'b0, 1'b1, 1, "R9");
        translate(32'h0077_7004, 8'd6, 1'b0, 1'b0, 0, "R9");
        // R10 context switch keeps other identifier's entries
        load_base(32'h0200_0000);
        translate(32'h0077_7008, 8'd7, 1'b0, 1'b0, 1, "R10");
        translate(32'h0077_700C, 8'd6, 1'b0, 1'b0, 0, "R10");
        load_base(32'h0010_0000);

        // Random traffic
        for (int n = 0; n < 400; n++) begin
            int r;
            r = int'($urandom % 40);
            if (r == 0) do_flush();
            else if (r == 1) load_base({8'h00, 4'($urandom), 20'h0});
            else
                translate({20'h00200 + 20'($urandom % 12), 12'($urandom)},
                          8'd1 + 8'($urandom % 3), ($urandom % 12) == 0,
                          ($urandom % 20) == 0, int'($urandom % 3), "R6");
        end

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule